// File: doc/BRIEF.md
# Mouse Movement Packet Receiver

This block listens to the two open-collector lines of a PS/2 pointing device and turns the serial traffic into movement reports. Both lines are sampled by a fast system clock. They pass through a synchroniser and a glitch filter before any bit is taken. The receiver assembles eleven-bit frames, checks each frame, and groups the bytes into three-byte reports. It then presents the button states, the signed displacement on each axis and the two overflow flags.

Each completed report is announced by a one-cycle strobe. A rejected frame raises a one-cycle error strobe. After an error, the receiver drops any partial report and searches again for a header byte. Two idle timers recover from a device that stops in the middle of a frame or in the middle of a report. All time limits are given as counts of system-clock cycles, so one netlist can serve any system clock rate.

Top module: `mouse_pkt_rx`

## Requirements
- R1: After reset, every output is 0: both strobes, both buttons, both overflow flags, and both movement values.
- R2: A frame is 11 bits, each taken on a filtered falling edge of the device clock: a 0 start bit, eight data bits with the least significant first, a parity bit, and a 1 stop bit. The link may run at any bit period within a 5:3 range without any change to the block.
- R3: A frame is rejected when the XOR of its eight data bits and its parity bit is 0, which means odd parity has failed.
- R4: A frame whose start bit is 1, or whose stop bit is 0, is rejected.
- R5: A byte that arrives while the receiver waits for a header is taken as a header only if its bit 3 is 1. Otherwise it is dropped without an error strobe, and the receiver goes on waiting.
- R6: When the third byte of a report is accepted, the outputs are set as follows. Left button is header bit 0. Right button is header bit 1. X overflow is header bit 6. Y overflow is header bit 7. moveX is {header bit 4, second byte} and moveY is {header bit 5, third byte}, both as 9-bit two's complement.
- R7: pktValid is high for exactly one cycle per report. The report outputs change only in that cycle.
- R8: A low pulse on the device clock that lasts fewer than FILT_LEN system cycles, or that follows a high phase shorter than FILT_LEN cycles, does not count as a bit.
- R9: If no falling edge arrives for FRAME_TO cycles while a frame is partly received, the partial frame is dropped without an error strobe.
- R10: If no falling edge arrives for PKT_TO cycles while a report is partly received, the partial report is dropped. A gap shorter than PKT_TO between frames of one report is accepted.
- R11: A rejected frame pulses frameErr for exactly one cycle. No report is produced in that cycle, and the receiver returns to waiting for a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ps2ClkIn | input | 1 | Device clock line, asynchronous |
| ps2DataIn | input | 1 | Device data line, asynchronous |
| btnLeft | output | 1 | Left button state from the last report |
| btnRight | output | 1 | Right button state from the last report |
| moveX | output | 9 | Signed X displacement, positive to the right |
| moveY | output | 9 | Signed Y displacement, positive upward |
| ovfX | output | 1 | X overflow flag |
| ovfY | output | 1 | Y overflow flag |
| pktValid | output | 1 | One-cycle strobe for a new report |
| frameErr | output | 1 | One-cycle strobe for a rejected frame |

## Verification
The hardest states to reach from the ports are the recovery paths, where the receiver must leave a half-built frame or report and come back aligned.

The stimulus reaches the frame timer by cutting a frame off after a few bits. It reaches the report timer by stopping after two good bytes. After each idle spell it sends a full report whose decoded fields differ from any misaligned reading, so a receiver that failed to resynchronise would report wrong values.

Header alignment is tested by sending a stray byte with bit 3 clear. Glitches are pulsed on the clock line just before a report, so that a single miscounted edge would turn the next frame into a parity or framing failure.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef struct packed {
    logic shift;
    logic takeHdr;
    logic takeX;
    logic commit;
    logic flagErr;
  } mrx_strobe_t;
endpackage

// File: rtl/mrx_line_in.sv
module mrx_line_in #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic ps2ClkIn,
  input  logic ps2DataIn,
  output logic fallSeen,
  output logic bitIn
);
  localparam int RW = $clog2(FILT_LEN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(FILT_LEN);

  logic [1:0] clkSync, dataSync;
  logic prevClk, armed;
  logic [RW-1:0] runCnt, runNext;
  logic fallNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= 2'b11;
      dataSync <= 2'b11;
    end else begin
      clkSync  <= {clkSync[0], ps2ClkIn};
      dataSync <= {dataSync[0], ps2DataIn};
    end
  end

  always_comb begin
    if (clkSync[1] != prevClk) runNext = RW'(1);
    else if (runCnt != RUN_MAX) runNext = runCnt + RW'(1);
    else runNext = runCnt;
    fallNow = armed && !clkSync[1] && (runNext == RUN_MAX) && (runCnt != RUN_MAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk  <= 1'b1;
      runCnt   <= '0;
      armed    <= 1'b0;
      fallSeen <= 1'b0;
      bitIn    <= 1'b1;
    end else begin
      prevClk  <= clkSync[1];
      runCnt   <= runNext;
      fallSeen <= fallNow;
      if (fallNow) bitIn <= dataSync[1];
      if (clkSync[1] && runNext == RUN_MAX) armed <= 1'b1;
      else if (fallNow) armed <= 1'b0;
    end
  end

  a_r8_fall_spacing: assert property (@(posedge clk) disable iff (!rstN)
    fallSeen |=> !fallSeen);
endmodule

// File: rtl/mrx_ctrl.sv
module mrx_ctrl
  import mrx_pkg::*;
#(
  parameter int FRAME_TO = 20000,
  parameter int PKT_TO   = 400000
) (
  input  logic clk,
  input  logic rstN,
  input  logic fallSeen,
  input  logic frameOk,
  input  logic hdrMark,
  output mrx_strobe_t st
);
  localparam int IW = $clog2(PKT_TO + 1);
  localparam logic [IW-1:0] FRAME_LIM = IW'(FRAME_TO);
  localparam logic [IW-1:0] PKT_LIM   = IW'(PKT_TO);
  localparam logic [3:0] LAST_BIT = 4'd10;

  logic [IW-1:0] idleCnt;
  logic [3:0] bitCnt;
  logic [1:0] byteIdx;
  logic evalPend;
  logic frameDrop, pktDrop;

  assign frameDrop = !fallSeen && (bitCnt != 4'd0) && (idleCnt == FRAME_LIM);
  assign pktDrop   = !fallSeen && !evalPend && (bitCnt == 4'd0) &&
                     (byteIdx != 2'd0) && (idleCnt == PKT_LIM);

  always_comb begin
    st = '0;
    st.shift = fallSeen;
    if (evalPend) begin
      if (!frameOk) st.flagErr = 1'b1;
      else begin
        unique case (byteIdx)
          2'd0:    st.takeHdr = hdrMark;
          2'd1:    st.takeX   = 1'b1;
          default: st.commit  = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt  <= '0;
      bitCnt   <= '0;
      byteIdx  <= '0;
      evalPend <= 1'b0;
    end else begin
      if (fallSeen) idleCnt <= '0;
      else if (idleCnt != PKT_LIM) idleCnt <= idleCnt + IW'(1);

      if (fallSeen) bitCnt <= (bitCnt == LAST_BIT) ? 4'd0 : bitCnt + 4'd1;
      else if (frameDrop) bitCnt <= 4'd0;

      evalPend <= fallSeen && (bitCnt == LAST_BIT);

      if (st.flagErr || st.commit || pktDrop) byteIdx <= 2'd0;
      else if (st.takeHdr) byteIdx <= 2'd1;
      else if (st.takeX) byteIdx <= 2'd2;
    end
  end

  a_r2_bit_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);
  a_r9_frame_drop: assert property (@(posedge clk) disable iff (!rstN)
    frameDrop |=> (bitCnt == 4'd0));
  a_r10_pkt_drop: assert property (@(posedge clk) disable iff (!rstN)
    pktDrop |=> (byteIdx == 2'd0));
endmodule

// File: rtl/mrx_dpath.sv
module mrx_dpath
  import mrx_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic bitIn,
  input  mrx_strobe_t st,
  output logic frameOk,
  output logic hdrMark,
  output logic btnLeft,
  output logic btnRight,
  output logic [8:0] moveX,
  output logic [8:0] moveY,
  output logic ovfX,
  output logic ovfY,
  output logic pktValid,
  output logic frameErr
);
  logic [10:0] frameSr;
  logic [7:0] hdrByte, xByte, curByte;

  assign curByte = frameSr[8:1];
  assign frameOk = !frameSr[0] && frameSr[10] && (^frameSr[9:1]);
  assign hdrMark = frameSr[4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSr  <= '1;
      hdrByte  <= '0;
      xByte    <= '0;
      btnLeft  <= 1'b0;
      btnRight <= 1'b0;
      moveX    <= '0;
      moveY    <= '0;
      ovfX     <= 1'b0;
      ovfY     <= 1'b0;
      pktValid <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (st.shift) frameSr <= {bitIn, frameSr[10:1]};
      if (st.takeHdr) hdrByte <= curByte;
      if (st.takeX) xByte <= curByte;
      pktValid <= st.commit;
      frameErr <= st.flagErr;
      if (st.commit) begin
        btnLeft  <= hdrByte[0];
        btnRight <= hdrByte[1];
        ovfX     <= hdrByte[6];
        ovfY     <= hdrByte[7];
        moveX    <= {hdrByte[4], xByte};
        moveY    <= {hdrByte[5], curByte};
      end
    end
  end

  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> !pktValid);
  a_r7_hold_move: assert property (@(posedge clk) disable iff (!rstN)
    !pktValid |-> ($stable(moveX) && $stable(moveY)));
  a_r11_err_single: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);
endmodule

// File: rtl/mouse_pkt_rx.sv
module mouse_pkt_rx
  import mrx_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int FRAME_TO = 20000,
  parameter int PKT_TO   = 400000
) (
  input  logic clk,
  input  logic rstN,
  input  logic ps2ClkIn,
  input  logic ps2DataIn,
  output logic btnLeft,
  output logic btnRight,
  output logic [8:0] moveX,
  output logic [8:0] moveY,
  output logic ovfX,
  output logic ovfY,
  output logic pktValid,
  output logic frameErr
);
  logic fallSeen, bitIn, frameOk, hdrMark;
  mrx_strobe_t st;

  mrx_line_in #(.FILT_LEN(FILT_LEN)) uLine (
    .clk(clk), .rstN(rstN), .ps2ClkIn(ps2ClkIn), .ps2DataIn(ps2DataIn),
    .fallSeen(fallSeen), .bitIn(bitIn)
  );

  mrx_ctrl #(.FRAME_TO(FRAME_TO), .PKT_TO(PKT_TO)) uCtrl (
    .clk(clk), .rstN(rstN), .fallSeen(fallSeen), .frameOk(frameOk),
    .hdrMark(hdrMark), .st(st)
  );

  mrx_dpath uDpath (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .st(st),
    .frameOk(frameOk), .hdrMark(hdrMark),
    .btnLeft(btnLeft), .btnRight(btnRight), .moveX(moveX), .moveY(moveY),
    .ovfX(ovfX), .ovfY(ovfY), .pktValid(pktValid), .frameErr(frameErr)
  );

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pktValid && frameErr));
endmodule

// File: tb/mouse_pkt_rx_test.sv
module mouse_pkt_rx_test;
  localparam int FILT = 3;
  localparam int FTO  = 200;
  localparam int PTO  = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ps2Clk = 1'b1;
  logic ps2Data = 1'b1;
  logic btnLeft, btnRight, ovfX, ovfY, pktValid, frameErr;
  logic [8:0] moveX, moveY;

  int checks = 0;
  int fails = 0;
  int pktCount = 0;
  int errCount = 0;
  int wideValid = 0;
  int wideErr = 0;
  int bothHigh = 0;
  bit done = 1'b0;
  logic prevValid = 1'b0;
  logic prevErr = 1'b0;
  logic capL, capR, capOx, capOy;
  logic [8:0] capX, capY;

  always #2.5 clk = ~clk;

  mouse_pkt_rx #(.FILT_LEN(FILT), .FRAME_TO(FTO), .PKT_TO(PTO)) uut (
    .clk(clk), .rstN(rstN), .ps2ClkIn(ps2Clk), .ps2DataIn(ps2Data),
    .btnLeft(btnLeft), .btnRight(btnRight), .moveX(moveX), .moveY(moveY),
    .ovfX(ovfX), .ovfY(ovfY), .pktValid(pktValid), .frameErr(frameErr)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (pktValid) begin
        pktCount++;
        capL = btnLeft; capR = btnRight; capOx = ovfX; capOy = ovfY;
        capX = moveX; capY = moveY;
        if (prevValid) wideValid++;
      end
      if (frameErr) begin
        errCount++;
        if (prevErr) wideErr++;
      end
      if (pktValid && frameErr) bothHigh++;
      prevValid = pktValid;
      prevErr = frameErr;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input int hp);
    ps2Data = b;
    cyc(hp / 2);
    ps2Clk = 1'b0;
    cyc(hp);
    ps2Clk = 1'b1;
    cyc(hp / 2);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int hp,
                           input bit badPar, input bit badStart, input bit badStop);
    sendBit(badStart, hp);
    for (int k = 0; k < 8; k++) sendBit(d[k], hp);
    sendBit((~^d) ^ badPar, hp);
    sendBit(~badStop, hp);
    ps2Data = 1'b1;
  endtask

  task automatic sendPacket(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input int hp, input int gap);
    sendFrame(b0, hp, 0, 0, 0); cyc(gap);
    sendFrame(b1, hp, 0, 0, 0); cyc(gap);
    sendFrame(b2, hp, 0, 0, 0); cyc(40);
  endtask

  task automatic checkPacket(input string req, input int pktBefore,
                             input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2);
    logic [8:0] ex, ey;
    ex = {b0[4], b1};
    ey = {b0[5], b2};
    chk(pktCount == pktBefore + 1, req, "report count", pktCount - pktBefore, 1);
    chk(capL == b0[0], req, "left button", capL, b0[0]);
    chk(capR == b0[1], req, "right button", capR, b0[1]);
    chk(capOx == b0[6], req, "x overflow", capOx, b0[6]);
    chk(capOy == b0[7], req, "y overflow", capOy, b0[7]);
    chk(capX == ex, req, "moveX", capX, ex);
    chk(capY == ey, req, "moveY", capY, ey);
  endtask

  initial begin
    cyc(200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0, e0;
    cyc(5);
    rstN = 1'b1;
    cyc(5);
    // R1 reset state
    chk(!pktValid && !frameErr, "R1", "strobes", pktValid + frameErr, 0);
    chk(!btnLeft && !btnRight && !ovfX && !ovfY, "R1", "flags",
        btnLeft + btnRight + ovfX + ovfY, 0);
    chk(moveX == 0 && moveY == 0, "R1", "movement", moveX + moveY, 0);

    // R2 R6 R7: sweep of header patterns at two bit periods
    for (int i = 0; i < 16; i++) begin
      logic [7:0] h, bx, by;
      h  = {i[1], i[0] ^ i[3], i[3], i[2], 1'b1, 1'b0, i[1], i[0]};
      bx = 8'(i * 17 + 3);
      by = 8'(255 - i * 13);
      p0 = pktCount;
      sendPacket(h, bx, by, (i < 8) ? 20 : 32, 30);
      checkPacket("R6", p0, h, bx, by);
    end
    chk(errCount == 0, "R2", "errors in clean traffic", errCount, 0);

    // R3 parity failure in the middle of a report
    p0 = pktCount; e0 = errCount;
    sendFrame(8'h09, 20, 0, 0, 0); cyc(30);
    sendFrame(8'h55, 20, 1, 0, 0); cyc(40);
    chk(errCount == e0 + 1, "R3", "error strobes", errCount - e0, 1);
    chk(pktCount == p0, "R3", "reports after bad parity", pktCount - p0, 0);
    sendPacket(8'h29, 8'hF0, 8'h0F, 20, 30);
    checkPacket("R3", p0, 8'h29, 8'hF0, 8'h0F);

    // R4 start bit of 1, then stop bit of 0
    p0 = pktCount; e0 = errCount;
    sendFrame(8'h08, 20, 0, 1, 0); cyc(40);
    chk(errCount == e0 + 1, "R4", "bad start error", errCount - e0, 1);
    sendFrame(8'h08, 20, 0, 0, 1); cyc(40);
    chk(errCount == e0 + 2, "R4", "bad stop error", errCount - e0, 2);
    chk(pktCount == p0, "R4", "reports after framing faults", pktCount - p0, 0);

    // R5 stray non-header bytes are skipped silently
    p0 = pktCount; e0 = errCount;
    sendFrame(8'h77, 20, 0, 0, 0); cyc(30);
    sendFrame(8'h00, 20, 0, 0, 0); cyc(30);
    sendPacket(8'h1A, 8'h80, 8'h7F, 20, 30);
    checkPacket("R5", p0, 8'h1A, 8'h80, 8'h7F);
    chk(errCount == e0, "R5", "errors on dropped bytes", errCount - e0, 0);

    // R8 glitches on the clock line just before a report
    p0 = pktCount; e0 = errCount;
    for (int g = 0; g < 4; g++) begin
      ps2Clk = 1'b0; cyc(FILT - 1); ps2Clk = 1'b1; cyc(FILT - 1);
    end
    cyc(FILT + 2);
    sendPacket(8'hC9, 8'h01, 8'hFE, 20, 30);
    checkPacket("R8", p0, 8'hC9, 8'h01, 8'hFE);
    chk(errCount == e0, "R8", "errors after glitches", errCount - e0, 0);

    // R9 partial frame abandoned, then clean report
    p0 = pktCount; e0 = errCount;
    sendBit(1'b0, 20); sendBit(1'b1, 20); sendBit(1'b1, 20); sendBit(1'b0, 20);
    ps2Data = 1'b1;
    cyc(FTO + 100);
    sendPacket(8'h3B, 8'h44, 8'hBB, 20, 30);
    checkPacket("R9", p0, 8'h3B, 8'h44, 8'hBB);
    chk(errCount == e0, "R9", "errors after frame timeout", errCount - e0, 0);

    // R10 long but legal gaps inside one report
    p0 = pktCount;
    sendPacket(8'h18, 8'hAA, 8'h55, 20, PTO / 2);
    checkPacket("R10", p0, 8'h18, 8'hAA, 8'h55);

    // R10 partial report abandoned after idle spell
    p0 = pktCount;
    sendFrame(8'h09, 20, 0, 0, 0); cyc(30);
    sendFrame(8'h12, 20, 0, 0, 0);
    cyc(PTO + 200);
    chk(pktCount == p0, "R10", "report from stale bytes", pktCount - p0, 0);
    sendPacket(8'h2A, 8'h33, 8'hC0, 20, 30);
    checkPacket("R10", p0, 8'h2A, 8'h33, 8'hC0);

    // R7 R11 strobe widths across the whole run
    chk(wideValid == 0, "R7", "multi-cycle report strobes", wideValid, 0);
    chk(wideErr == 0, "R11", "multi-cycle error strobes", wideErr, 0);
    chk(bothHigh == 0, "R11", "error with report", bothHigh, 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule